// File: doc/BRIEF.md
# Bus-Attached Serial Port with Interrupt Logic

A register-mapped serial port that sits on an APB bus and moves 8-bit characters over a single transmit line and a single receive line, each character framed as one low start bit, eight data bits sent least significant first, and one high stop bit. Software writes a byte into a one-byte transmit holding register. Received characters land in a one-byte receive holding register that software empties by reading it. A 20-bit divider sets the length of every serial bit directly in bus clocks.

Four event sources are reported on their own interrupt lines: transmit done, receive done, transmit overrun and receive overrun. A fifth line is the OR of all four. The transmit and receive done events are latched and cleared by software. The overrun lines are not latched: each one follows its sticky status flag gated by its enable. A block of twelve read-only identification words completes the register map.

Top module: `serial_port_apb`

## Requirements
- R1: After reset every readable register returns 0, the serial output is high and all five interrupt outputs are low.
- R2: The status word (offset 0x04) holds transmit-full at bit 0, receive-full at bit 1, transmit-overrun at bit 2 and receive-overrun at bit 3. Bits 0 and 1 are not changed by writes. Writing 1 to bit 2 or bit 3 clears that overrun flag. An overrun flag stays set until it is cleared this way.
- R3: The control word (offset 0x08) keeps only bits 6:0: bit 0 transmit enable, bit 1 receive enable, bit 2 transmit-done interrupt enable, bit 3 receive-done interrupt enable, bit 4 transmit-overrun interrupt enable, bit 5 receive-overrun interrupt enable, bit 6 a stored test bit with no effect.
- R4: A character whose stop bit reads 1 is handled at its stop-bit sample point. With receive disabled it is discarded. With receive-full set it sets receive-overrun and the held byte is kept. Otherwise it is stored, receive-full is set, and the receive-done interrupt is latched if its enable is on. A character whose stop bit reads 0 is dropped.
- R5: Reading the data word (offset 0x00) returns the held receive byte in bits 7:0 and clears receive-full.
- R6: Writing the data word while transmit-full is set sets transmit-overrun and leaves the held byte unchanged. Otherwise the write loads bits 7:0 and sets transmit-full.
- R7: A transmission starts the cycle after transmit is enabled, transmit-full is set, the divider is valid and the line is idle. Each of the ten bits lasts exactly divider clocks, and transmit-full clears at the end of the stop bit. The output is high whenever no character is being sent.
- R8: The transmit-done interrupt is latched when transmit-full clears at the end of a character while its enable is on.
- R9: The interrupt word (offset 0x0C) reads transmit-done at bit 0, receive-done at bit 1, transmit-overrun at bit 2 and receive-overrun at bit 3. Writing 1 to bit 0 or bit 1 clears that latched bit. Writing 1 to bit 2 or bit 3 clears the matching overrun flag in the status word.
- R10: Each overrun interrupt output is the live AND of its status flag and its enable. Changing the enable changes the output without touching the flag.
- R11: The combined interrupt output is high exactly when any of the four interrupt bits is high.
- R12: The divider (offset 0x10, bits 19:0) is valid only when it is at least 16 and at most the CLK_HZ parameter. With an invalid divider no character is started.
- R13: Offsets 0xFD0 to 0xFFC read twelve fixed identification bytes, in order 04 00 00 00 21 B8 1B 00 0D F0 05 B1. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive-done interrupt |
| irq_txovr | output | 1 | Transmit-overrun interrupt |
| irq_rxovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of all interrupts |

## Verification
The transmitter is driven with the bytes 0x55, 0x00, 0xFF and 0x3C at two divider values, so that the per-clock line comparison can detect a swapped bit order, a stuck bit or a bit that is one clock too short or too long. The receiver gets a clean character with receive disabled, with receive enabled, a second character that arrives while the first is still held, and a character with a bad stop bit. Each case should produce a different buffer and flag result. Divider values below 16, above the clock bound and valid show whether the start is gated correctly. Overrun flags are cleared through the status word and then through the interrupt word, with their enables switched both ways, which separates the sticky flag from the live interrupt.

// File: rtl/sp_pkg.sv
// Shared constants for the serial port: register word addresses, control
// bit positions and the identification byte table.
// Assumes a 4 KiB register window addressed by 32-bit words.
package sp_pkg;
    localparam logic [9:0] A_DATA   = 10'h000;
    localparam logic [9:0] A_STAT   = 10'h001;
    localparam logic [9:0] A_CTRL   = 10'h002;
    localparam logic [9:0] A_INT    = 10'h003;
    localparam logic [9:0] A_DIV    = 10'h004;
    localparam logic [9:0] A_IDBASE = 10'h3F4;

    localparam int C_TXEN  = 0;
    localparam int C_RXEN  = 1;
    localparam int C_TXIE  = 2;
    localparam int C_RXIE  = 3;
    localparam int C_TXOIE = 4;
    localparam int C_RXOIE = 5;
    localparam int CTRL_W  = 7;

    localparam int FRAME_BITS = 10;

    // Identification byte for word index 0..11 of the ID block.
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:  id_byte = 8'h04;
            4'd4:  id_byte = 8'h21;
            4'd5:  id_byte = 8'hB8;
            4'd6:  id_byte = 8'h1B;
            4'd8:  id_byte = 8'h0D;
            4'd9:  id_byte = 8'hF0;
            4'd10: id_byte = 8'h05;
            4'd11: id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/sp_tx.sv
// Transmit shifter: sends one 8N1 character per start pulse.
// Assumes start is only pulsed while busy is low and div >= 2.
// The divider is captured at start so a later change cannot stretch a frame.
module sp_tx #(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             done,
    output logic             txd
);
    import sp_pkg::*;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [3:0]       bitn;
    logic [FRAME_BITS-1:0] shreg;
    logic             wrap;

    assign wrap = (cnt == div_q - 1'b1);
    // Last clock of the stop bit.
    assign done = busy && wrap && (bitn == 4'(FRAME_BITS - 1));
    // Line idles high; while busy, the low bit of the shifter is on the line.
    assign txd  = busy ? shreg[0] : 1'b1;

    // Frame sequencer: bit timer, bit counter and shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '1;
            div_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt   <= '0;
                bitn  <= '0;
                shreg <= {1'b1, data, 1'b0};
                div_q <= div;
            end
        end else if (wrap) begin
            cnt <= '0;
            if (done) begin
                busy <= 1'b0;
            end else begin
                bitn  <= bitn + 1'b1;
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sp_rx.sv
// Receive sampler: synchronises the line, detects a falling edge as a start
// bit and samples each bit at its middle clock. It pulses got for one
// clock at the stop-bit sample point, but only if the stop bit reads 1.
// Assumes div >= 16 whenever en is high.
module sp_rx #(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rxd,
    input  logic [DIV_W-1:0] div,
    output logic             got,
    output logic [7:0]       data
);
    import sp_pkg::*;

    logic             s1, s2, prev;
    logic             busy;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [3:0]       bitn;
    logic [7:0]       shreg;
    logic             sample, wrap, last;

    assign sample = (cnt == (div_q >> 1));
    assign wrap   = (cnt == div_q - 1'b1);
    assign last   = busy && sample && (bitn == 4'(FRAME_BITS - 1));
    assign got    = last && s2;
    assign data   = shreg;

    // Two-stage synchroniser plus an edge-history flop; all reset to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Frame sequencer: start detection, bit timer and data shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            div_q <= '0;
        end else if (!busy) begin
            if (en && prev && !s2) begin
                busy  <= 1'b1;
                cnt   <= '0;
                bitn  <= '0;
                div_q <= div;
            end
        end else if (last) begin
            busy <= 1'b0;
        end else begin
            if (sample && bitn != 4'd0)
                shreg <= {s2, shreg[7:1]};
            if (wrap) begin
                cnt  <= '0;
                bitn <= bitn + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_port_apb.sv
// APB serial port: register file, status and interrupt logic around one
// transmit shifter and one receive sampler. Holds one byte per direction.
// Assumes zero-wait-state APB (access completes in the penable cycle) and
// DIV_W <= 32.
module serial_port_apb
    import sp_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int          DIV_W  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq_tx,
    output logic        irq_rx,
    output logic        irq_txovr,
    output logic        irq_rxovr,
    output logic        irq_any
);
    localparam int unsigned DIV_MIN = 16;

    logic [CTRL_W-1:0] ctrl;
    logic [DIV_W-1:0]  div_q;
    logic [7:0]        tx_buf, rx_buf;
    logic              tx_full, rx_full, tx_ovr, rx_ovr;
    logic              itx_q, irx_q;

    logic [9:0]  waddr;
    logic        acc_wr, acc_rd;
    logic        wr_data, wr_stat, wr_ctrl, wr_int, wr_div, rd_data;
    logic        clr_txovr, clr_rxovr;
    logic        div_ok, tx_start, tx_busy, tx_done;
    logic        rx_got, rx_commit;
    logic [7:0]  rx_byte;
    logic        unused_bits;

    assign unused_bits = ^{pwdata[31:DIV_W], paddr[1:0]};

    assign waddr   = paddr[11:2];
    assign acc_wr  = psel && penable && pwrite;
    assign acc_rd  = psel && penable && !pwrite;
    assign wr_data = acc_wr && waddr == A_DATA;
    assign wr_stat = acc_wr && waddr == A_STAT;
    assign wr_ctrl = acc_wr && waddr == A_CTRL;
    assign wr_int  = acc_wr && waddr == A_INT;
    assign wr_div  = acc_wr && waddr == A_DIV;
    assign rd_data = acc_rd && waddr == A_DATA;

    // Overrun flags can be cleared from either the status or interrupt word.
    assign clr_txovr = (wr_stat || wr_int) && pwdata[2];
    assign clr_rxovr = (wr_stat || wr_int) && pwdata[3];

    assign div_ok    = (32'(div_q) >= DIV_MIN) && (32'(div_q) <= CLK_HZ);
    assign tx_start  = ctrl[C_TXEN] && tx_full && !tx_busy && div_ok;
    assign rx_commit = rx_got && ctrl[C_RXEN];

    sp_tx #(.DIV_W(DIV_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (tx_buf),
        .div   (div_q),
        .busy  (tx_busy),
        .done  (tx_done),
        .txd   (txd)
    );

    sp_rx #(.DIV_W(DIV_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_ok),
        .rxd   (rxd),
        .div   (div_q),
        .got   (rx_got),
        .data  (rx_byte)
    );

    // Configuration registers: control and divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            div_q <= '0;
        end else begin
            if (wr_ctrl) ctrl  <= pwdata[CTRL_W-1:0];
            if (wr_div)  div_q <= pwdata[DIV_W-1:0];
        end
    end

    // Transmit holding byte, full flag and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
            tx_ovr  <= 1'b0;
        end else begin
            if (tx_done)
                tx_full <= 1'b0;
            if (wr_data && !tx_full) begin
                tx_buf  <= pwdata[7:0];
                tx_full <= 1'b1;
            end
            if (wr_data && tx_full)
                tx_ovr <= 1'b1;
            else if (clr_txovr)
                tx_ovr <= 1'b0;
        end
    end

    // Receive holding byte, full flag and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
        end else begin
            if (rx_commit && !rx_full) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end
            if (rx_commit && rx_full)
                rx_ovr <= 1'b1;
            else if (clr_rxovr)
                rx_ovr <= 1'b0;
        end
    end

    // Latched done interrupts; setting wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            itx_q <= 1'b0;
            irx_q <= 1'b0;
        end else begin
            if (tx_done && ctrl[C_TXIE])
                itx_q <= 1'b1;
            else if (wr_int && pwdata[0])
                itx_q <= 1'b0;
            if (rx_commit && !rx_full && ctrl[C_RXIE])
                irx_q <= 1'b1;
            else if (wr_int && pwdata[1])
                irx_q <= 1'b0;
        end
    end

    // Interrupt outputs: overrun lines are live, not latched.
    always_comb begin
        irq_tx    = itx_q;
        irq_rx    = irx_q;
        irq_txovr = tx_ovr && ctrl[C_TXOIE];
        irq_rxovr = rx_ovr && ctrl[C_RXOIE];
        irq_any   = irq_tx || irq_rx || irq_txovr || irq_rxovr;
    end

    // Read data multiplexer.
    always_comb begin
        prdata = '0;
        if (waddr >= A_IDBASE) begin
            prdata[7:0] = id_byte(4'(waddr - A_IDBASE));
        end else begin
            case (waddr)
                A_DATA: prdata[7:0]        = rx_buf;
                A_STAT: prdata[3:0]        = {rx_ovr, tx_ovr, rx_full, tx_full};
                A_CTRL: prdata[CTRL_W-1:0] = ctrl;
                A_INT:  prdata[3:0]        = {irq_rxovr, irq_txovr, irq_rx, irq_tx};
                A_DIV:  prdata[DIV_W-1:0]  = div_q;
                default: prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sp_checker.sv
// Temporal checks on the serial port's buffer flags, interrupt causes and
// serial line. It observes only; it is attached to every instance by bind.
module sp_checker
    import sp_pkg::*;
#(
    parameter int DIV_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_wr,
    input logic             acc_rd,
    input logic [9:0]       waddr,
    input logic [31:0]      pwdata,
    input logic             tx_full,
    input logic             tx_done,
    input logic             tx_busy,
    input logic             tx_ovr,
    input logic             rx_full,
    input logic             rx_commit,
    input logic [DIV_W-1:0] div_q,
    input logic             txd,
    input logic             irq_tx
);
    // R7: a full transmit byte stays held until its frame ends.
    p_txfull_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && !tx_done |=> tx_full);

    // R7: the line is high whenever the shifter is idle.
    p_txd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R8: the transmit-done interrupt only rises after a frame end.
    p_txirq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> $past(tx_done));

    // R2: transmit overrun is sticky unless a clearing write hits bit 2.
    p_txovr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovr && !(acc_wr && (waddr == A_STAT || waddr == A_INT) && pwdata[2])
        |=> tx_ovr);

    // R5: a data read with no arriving byte leaves the receive buffer empty.
    p_rxfull_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd && waddr == A_DATA && !rx_commit |=> !rx_full);

    // R12: a frame never starts with a divider below the minimum.
    p_start_div_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> 32'(div_q) >= 32'd16);
endmodule

bind serial_port_apb sp_checker #(.DIV_W(DIV_W)) u_sp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .waddr     (waddr),
    .pwdata    (pwdata),
    .tx_full   (tx_full),
    .tx_done   (tx_done),
    .tx_busy   (tx_busy),
    .tx_ovr    (tx_ovr),
    .rx_full   (rx_full),
    .rx_commit (rx_commit),
    .div_q     (div_q),
    .txd       (txd),
    .irq_tx    (irq_tx)
);

// File: tb/tb_serial_port_apb.sv
// Bench: a behavioural model advanced on every rising edge, compared with
// the line and interrupt outputs on every falling edge, plus register reads.
module tb_serial_port_apb;
    localparam int unsigned CLK_HZ = 50_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rxd = 1'b1;
    logic        txd, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_port_apb #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr), .irq_any(irq_any)
    );

    // ---------------- reference model state ----------------
    logic [6:0] m_ctrl;
    int         m_div, m_txdiv, m_rem;
    logic [7:0] m_txbuf, m_rxbuf, m_txdata;
    logic       m_txfull, m_rxfull, m_txovr, m_rxovr, m_itx, m_irx, m_busy;
    int         rx_cd = 0;
    logic [7:0] rx_byte = '0;
    logic       rx_stop = 1'b1;
    int         cur_div = 16;

    logic mw, mr, mdone, mstart, mgot, mcommit, old_txf, old_rxf;
    int   mwa;

    function automatic bit div_valid(input int d);
        return d >= 16 && d <= int'(CLK_HZ);
    endfunction

    function automatic logic [7:0] id_exp(input int i);
        case (i)
            0: return 8'h04;  4: return 8'h21;  5: return 8'hB8;  6: return 8'h1B;
            8: return 8'h0D;  9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    // Model update: all decisions use pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_div = 0; m_txdiv = 16; m_rem = 0;
            m_txbuf = '0; m_rxbuf = '0; m_txdata = '0;
            m_txfull = 0; m_rxfull = 0; m_txovr = 0; m_rxovr = 0;
            m_itx = 0; m_irx = 0; m_busy = 0;
        end else begin
            mw  = psel && penable && pwrite;
            mr  = psel && penable && !pwrite;
            mwa = int'(paddr[11:2]);
            mdone  = m_busy && m_rem == 1;
            mstart = !m_busy && m_txfull && m_ctrl[0] && div_valid(m_div);
            mgot = 0;
            if (rx_cd > 0) begin
                rx_cd = rx_cd - 1;
                if (rx_cd == 0 && rx_stop) mgot = 1;
            end
            mcommit = mgot && m_ctrl[1];
            old_txf = m_txfull;
            old_rxf = m_rxfull;

            if (mdone) m_busy = 0;
            else if (m_busy) m_rem = m_rem - 1;
            else if (mstart) begin
                m_busy = 1; m_rem = 10 * m_div; m_txdiv = m_div; m_txdata = m_txbuf;
            end

            if (mdone) m_txfull = 0;
            if (mw && mwa == 0 && !old_txf) begin m_txfull = 1; m_txbuf = pwdata[7:0]; end
            if (mw && mwa == 0 && old_txf) m_txovr = 1;
            else if (mw && (mwa == 1 || mwa == 3) && pwdata[2]) m_txovr = 0;

            if (mcommit && !old_rxf) begin m_rxfull = 1; m_rxbuf = rx_byte; end
            else if (mr && mwa == 0) m_rxfull = 0;
            if (mcommit && old_rxf) m_rxovr = 1;
            else if (mw && (mwa == 1 || mwa == 3) && pwdata[3]) m_rxovr = 0;

            if (mdone && m_ctrl[2]) m_itx = 1;
            else if (mw && mwa == 3 && pwdata[0]) m_itx = 0;
            if (mcommit && !old_rxf && m_ctrl[3]) m_irx = 1;
            else if (mw && mwa == 3 && pwdata[1]) m_irx = 0;

            if (mw && mwa == 2) m_ctrl = pwdata[6:0];
            if (mw && mwa == 4) m_div = int'(pwdata[19:0]);
        end
    end

    function automatic logic m_txd();
        int el, b;
        if (!m_busy) return 1'b1;
        el = 10 * m_txdiv - m_rem;
        b  = el / m_txdiv;
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return m_txdata[b-1];
    endfunction

    function automatic logic [31:0] model_read(input int wa);
        logic ito, iro;
        ito = m_txovr && m_ctrl[4];
        iro = m_rxovr && m_ctrl[5];
        if (wa >= 'h3F4) return {24'd0, id_exp(wa - 'h3F4)};
        case (wa)
            0: return {24'd0, m_rxbuf};
            1: return {28'd0, m_rxovr, m_txovr, m_rxfull, m_txfull};
            2: return {25'd0, m_ctrl};
            3: return {28'd0, iro, ito, m_irx, m_itx};
            4: return 32'(m_div);
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of the line and interrupt outputs.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R7 txd", {31'd0, txd}, {31'd0, m_txd()});
            check("R8 irq_tx", {31'd0, irq_tx}, {31'd0, m_itx});
            check("R4 irq_rx", {31'd0, irq_rx}, {31'd0, m_irx});
            check("R10 irq_txovr", {31'd0, irq_txovr}, {31'd0, m_txovr && m_ctrl[4]});
            check("R10 irq_rxovr", {31'd0, irq_rxovr}, {31'd0, m_rxovr && m_ctrl[5]});
            check("R11 irq_any", {31'd0, irq_any},
                  {31'd0, m_itx || m_irx || (m_txovr && m_ctrl[4]) || (m_rxovr && m_ctrl[5])});
        end
    end

    // ---------------- bus and line drivers ----------------
    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [11:0] a, input string tag, output logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1;
        d = prdata;
        check(tag, d, model_read(int'(a[11:2])));
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stp);
        @(negedge clk);
        rxd = 0; rx_byte = b; rx_stop = stp;
        rx_cd = 4 + 9 * cur_div + cur_div / 2;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (cur_div) @(negedge clk);
        end
        rxd = stp;
        repeat (cur_div) @(negedge clk);
        rxd = 1;
        repeat (2 * cur_div) @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin : main
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state.
        check("R1 txd idle", {31'd0, txd}, 32'd1);
        check("R1 irq_any", {31'd0, irq_any}, 32'd0);
        for (int a = 0; a <= 'h10; a += 4) begin
            apb_read(12'(a), "R1 reg after reset", d);
            check("R1 reg zero", d, 32'd0);
        end

        // R13: identification block, write ignored.
        for (int i = 0; i < 12; i++) apb_read(12'('hFD0 + 4 * i), "R13 id", d);
        apb_read(12'hFE4, "R13 id B8", d);
        check("R13 id B8", d, 32'hB8);
        apb_write(12'hFE4, 32'hFF);
        apb_read(12'hFE4, "R13 id after write", d);
        check("R13 id unchanged", d, 32'hB8);

        // R3: control keeps seven bits.
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_read(12'h008, "R3 ctrl", d);
        check("R3 ctrl width", d, 32'h7F);
        apb_write(12'h008, 32'h0);

        // R12: divider below minimum blocks transmit.
        apb_write(12'h010, 32'd8);
        apb_write(12'h008, 32'h05);
        apb_write(12'h000, 32'h55);
        wait_clk(200);
        apb_read(12'h004, "R12 still full", d);
        check("R12 no start low div", d, 32'h1);
        // R7/R8: valid divider starts the frame; done interrupt latched.
        cur_div = 16;
        apb_write(12'h010, 32'd16);
        wait_clk(10 * 16 + 6);
        check("R8 irq_tx after frame", {31'd0, irq_tx}, 32'd1);
        apb_read(12'h004, "R7 full cleared", d);
        check("R7 status empty", d, 32'h0);
        // R9: clear the done interrupt.
        apb_write(12'h00C, 32'h1);
        apb_read(12'h00C, "R9 int cleared", d);
        check("R9 int zero", d, 32'h0);

        // R6/R10/R2: overrun while transmit disabled.
        apb_write(12'h008, 32'h00);
        apb_write(12'h000, 32'h11);
        apb_write(12'h000, 32'h22);
        apb_read(12'h004, "R6 overrun set", d);
        check("R6 status full+ovr", d, 32'h5);
        check("R10 masked", {31'd0, irq_txovr}, 32'd0);
        apb_write(12'h008, 32'h10);
        wait_clk(1);
        check("R10 live enable", {31'd0, irq_txovr}, 32'd1);
        apb_write(12'h004, 32'h3);
        apb_read(12'h004, "R2 ro bits", d);
        check("R2 ro bits kept", d, 32'h5);
        apb_write(12'h004, 32'h4);
        apb_read(12'h004, "R2 w1c", d);
        check("R2 ovr cleared", d, 32'h1);
        // R6: held byte is the first one; send it (txd compared per clock).
        apb_write(12'h008, 32'h15);
        wait_clk(10 * 16 + 6);
        apb_write(12'h000, 32'h00);
        apb_write(12'h000, 32'h01);
        wait_clk(10 * 16 + 6);
        apb_read(12'h00C, "R9 before clear", d);
        check("R9 ovr in int", d, 32'h5);
        apb_write(12'h00C, 32'h4);
        apb_read(12'h004, "R9 int clears status", d);
        check("R9 status ovr gone", d, 32'h0);
        apb_write(12'h00C, 32'h1);

        // R7: other patterns at another divider.
        cur_div = 20;
        apb_write(12'h010, 32'd20);
        apb_write(12'h000, 32'hFF);
        wait_clk(10 * 20 + 6);
        apb_write(12'h000, 32'h3C);
        wait_clk(10 * 20 + 6);
        apb_write(12'h00C, 32'h1);

        // R4: receive disabled drops the byte.
        apb_write(12'h008, 32'h08);
        send_rx(8'h5A, 1);
        apb_read(12'h004, "R4 rx disabled", d);
        check("R4 dropped", d, 32'h0);

        // R4/R5: receive enabled.
        apb_write(12'h008, 32'h0A);
        send_rx(8'hA5, 1);
        check("R4 irq_rx", {31'd0, irq_rx}, 32'd1);
        apb_read(12'h000, "R5 data", d);
        check("R5 byte", d, 32'hA5);
        apb_read(12'h004, "R5 full cleared", d);
        check("R5 status", d, 32'h0);
        apb_write(12'h00C, 32'h2);

        // R4/R10: second byte while full sets overrun, first kept.
        apb_write(12'h008, 32'h2A);
        send_rx(8'h81, 1);
        send_rx(8'h7E, 1);
        apb_read(12'h004, "R4 rx overrun", d);
        check("R4 full+ovr", d, 32'hA);
        check("R10 irq_rxovr", {31'd0, irq_rxovr}, 32'd1);
        apb_read(12'h000, "R4 first kept", d);
        check("R4 first byte", d, 32'h81);
        apb_write(12'h00C, 32'hA);
        apb_read(12'h004, "R9 rx ovr clear", d);
        check("R9 rx status", d, 32'h0);

        // R4: bad stop bit is dropped.
        send_rx(8'hC3, 0);
        apb_read(12'h004, "R4 bad stop", d);
        check("R4 bad stop dropped", d, 32'h0);

        // R12: divider above clock bound blocks transmit.
        apb_write(12'h010, 32'd60000);
        apb_write(12'h008, 32'h01);
        apb_write(12'h000, 32'h99);
        wait_clk(100);
        apb_read(12'h004, "R12 high div", d);
        check("R12 no start high div", d, 32'h1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule